// File: doc/BRIEF.md
# Peripheral Access Burst Sequencer

This block drives the peripheral side of one transfer descriptor. A one-cycle start pulse captures the descriptor's peripheral settings: base address, unit count, unit width, the address step and whether it applies, burst size, inter-burst delay, direction and byte reversal. The block then issues one read or write strobe per unit. Each strobe holds its address until the peripheral signals ready. Accesses are grouped into bursts, and a programmed quiet interval separates consecutive bursts.

The data path is combinational in both directions. Words going to the peripheral, and words returning from it, can have their bytes reversed within the unit width that was captured. After the last unit is accepted, a single-cycle done pulse tells the surrounding engine that the descriptor is finished. Fetching descriptors and driving the memory side are handled elsewhere.

Top module: `periph_burst_seq`

## Requirements
- R1: After reset the block is idle: `per_rd`, `per_wr`, `busy` and `done` are all 0.
- R2: When `cfg_dir` is 0, accesses use `per_wr` (memory to peripheral). When it is 1, they use `per_rd` (peripheral to memory). The two strobes are never high together.
- R3: The first access uses `cfg_addr`. After each accepted unit with `cfg_incr_en`=1, the address grows by 4, 2 or 1 bytes for `cfg_step` codes 0, 1 and 2 (code 3 also steps 1). With `cfg_incr_en`=0, every access uses the base address.
- R4: While a strobe is high and `per_ready` is low, the strobe, its direction and `per_addr` stay unchanged.
- R5: A descriptor with `cfg_len`=N units produces exactly N accepted accesses. `done` is high for exactly one cycle, in the cycle after the last acceptance, and `busy` falls with it. With N=0, `done` pulses in the cycle after start and no strobe appears.
- R6: Accesses are grouped into bursts of `cfg_burst` units (1 to 7). A `cfg_burst` of 0 gives bursts of one unit.
- R7: After every burst except the final one, the strobe stays low for exactly `cfg_gap` x 256 cycles (0 to 1792). There is no gap after the final burst, and code 0 gives back-to-back bursts.
- R8: With `cfg_swap`=1, bytes are reversed within the unit. For width code 0 (32-bit) all four bytes are reversed. For code 1 (16-bit) bits 7:0 and 15:8 are exchanged and bits 31:16 pass unchanged. Code 2 (8-bit) passes data unchanged. With `cfg_swap`=0 data passes unchanged. This applies to `per_wdata` from `mem_wdata` and to `mem_rdata` from `per_rdata`.
- R9: All configuration is captured at start. A start pulse or configuration change while `busy` is high has no effect on the running descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a descriptor (taken only when idle) |
| cfg_addr | input | ADDR_W | Peripheral base address |
| cfg_len | input | LEN_W | Number of units to move |
| cfg_unit_w | input | 2 | Unit width: 0=32-bit, 1=16-bit, 2=8-bit |
| cfg_incr_en | input | 1 | 1 = step the address after each unit |
| cfg_step | input | 2 | Step code: 0=4, 1=2, 2/3=1 byte |
| cfg_burst | input | 3 | Units per burst (0 means 1) |
| cfg_gap | input | 3 | Inter-burst delay in 256-cycle steps |
| cfg_dir | input | 1 | 0 = memory to peripheral, 1 = peripheral to memory |
| cfg_swap | input | 1 | 1 = reverse bytes within unit |
| per_ready | input | 1 | Peripheral accepts the current access |
| per_rdata | input | 32 | Data returned by the peripheral |
| mem_wdata | input | 32 | Data to be written to the peripheral |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_addr | output | ADDR_W | Address of the current access |
| per_wdata | output | 32 | Write data after optional byte reversal |
| mem_rdata | output | 32 | Read data after optional byte reversal |
| busy | output | 1 | A descriptor is in progress |
| done | output | 1 | One-cycle pulse after the last unit |

## Verification
On every cycle, the embedded properties check that:
- the two strobes never overlap;
- a stalled access keeps its strobe and address;
- a static address does not move;
- the burst counter never reaches the burst length;
- the gap state always has a live timer;
- `done` never lasts two cycles.

Only the bench's scenarios can show the following:
- the exact address sequence for each step code;
- the precise length of each inter-burst gap, including its absence after the final burst;
- the unit count;
- the byte order for each width;
- that configuration changed mid-transfer is ignored.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int DW = 32;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_ACC  = 2'd1,
        SQ_GAP  = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic [1:0] unit_w;
        logic       incr_en;
        logic [1:0] step;
        logic [2:0] burst;
        logic [2:0] gap;
        logic       dir;
        logic       swap;
    } ctl_cfg_t;

    function automatic logic [2:0] step_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd4;
            2'd1:    return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

    function automatic logic [2:0] burst_units(input logic [2:0] b);
        return (b == 3'd0) ? 3'd1 : b;
    endfunction

    function automatic logic [DW-1:0] lane_rev(input logic [DW-1:0] d,
                                               input logic [1:0] w);
        case (w)
            2'd0:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
            2'd1:    return {d[31:16], d[7:0], d[15:8]};
            default: return d;
        endcase
    endfunction

endpackage

// File: rtl/pbs_addr_gen.sv
module pbs_addr_gen
    import pbs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              adv,
    input  logic              incr_en,
    input  logic [1:0]        step,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (load) begin
            addr <= base;
        end else if (adv && incr_en) begin
            addr <= addr + ADDR_W'(step_bytes(step));
        end
    end

    // R3: a static address does not move when a unit is accepted
    assert_static_addr_R3: assert property (@(posedge clk) disable iff (rst)
        (!load && adv && !incr_en) |=> (addr == $past(addr)));

endmodule

// File: rtl/pbs_gap_timer.sv
module pbs_gap_timer #(
    parameter int GAP_UNIT = 256,
    parameter int CODE_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CODE_W-1:0] code,
    output logic              last,
    output logic              running
);

    localparam int MAX_GAP = ((1 << CODE_W) - 1) * GAP_UNIT;
    localparam int CNT_W   = $clog2(MAX_GAP + 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= CNT_W'(int'(code) * GAP_UNIT);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last    = (cnt == CNT_W'(1));
    assign running = (cnt != '0);

endmodule

// File: rtl/pbs_seq_fsm.sv
module pbs_seq_fsm
    import pbs_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [LEN_W-1:0] len_in,
    input  logic [2:0]       burst,
    input  logic             gap_en,
    input  logic             ready,
    input  logic             timer_last,
    input  logic             timer_running,
    output logic             active,
    output logic             accept,
    output logic             gap_load,
    output logic             busy,
    output logic             done
);

    sq_state_e        state;
    logic [LEN_W-1:0] rem;
    logic [2:0]       bcnt;
    logic [2:0]       blen;
    logic             final_unit;
    logic             burst_end;

    assign blen       = burst_units(burst);
    assign active     = (state == SQ_ACC);
    assign accept     = active && ready;
    assign final_unit = (rem == LEN_W'(1));
    assign burst_end  = ((bcnt + 3'd1) == blen);
    assign gap_load   = accept && !final_unit && burst_end && gap_en;
    assign busy       = (state != SQ_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            rem   <= '0;
            bcnt  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (take) begin
                        rem  <= len_in;
                        bcnt <= '0;
                        if (len_in == '0) begin
                            done <= 1'b1;
                        end else begin
                            state <= SQ_ACC;
                        end
                    end
                end
                SQ_ACC: begin
                    if (ready) begin
                        rem <= rem - 1'b1;
                        if (final_unit) begin
                            state <= SQ_IDLE;
                            done  <= 1'b1;
                        end else if (burst_end) begin
                            bcnt <= '0;
                            if (gap_en) state <= SQ_GAP;
                        end else begin
                            bcnt <= bcnt + 3'd1;
                        end
                    end
                end
                SQ_GAP: begin
                    if (timer_last) state <= SQ_ACC;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // R5: done never lasts two cycles
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: the position inside a burst stays below the burst length
    assert_burst_bound_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bcnt < blen));

    // R7: the quiet interval is always backed by a running timer
    assert_gap_timer_live_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_GAP) |-> timer_running);

endmodule

// File: rtl/periph_burst_seq.sv
module periph_burst_seq
    import pbs_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int GAP_UNIT = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [1:0]        cfg_unit_w,
    input  logic              cfg_incr_en,
    input  logic [1:0]        cfg_step,
    input  logic [2:0]        cfg_burst,
    input  logic [2:0]        cfg_gap,
    input  logic              cfg_dir,
    input  logic              cfg_swap,
    input  logic              per_ready,
    input  logic [DW-1:0]     per_rdata,
    input  logic [DW-1:0]     mem_wdata,
    output logic              per_rd,
    output logic              per_wr,
    output logic [ADDR_W-1:0] per_addr,
    output logic [DW-1:0]     per_wdata,
    output logic [DW-1:0]     mem_rdata,
    output logic              busy,
    output logic              done
);

    ctl_cfg_t cfg_q;
    logic     take;
    logic     active;
    logic     accept;
    logic     gap_load;
    logic     timer_last;
    logic     timer_running;

    assign take = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (take) begin
            cfg_q <= '{unit_w: cfg_unit_w, incr_en: cfg_incr_en, step: cfg_step,
                       burst: cfg_burst, gap: cfg_gap, dir: cfg_dir,
                       swap: cfg_swap};
        end
    end

    pbs_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .take         (take),
        .len_in       (cfg_len),
        .burst        (cfg_q.burst),
        .gap_en       (cfg_q.gap != 3'd0),
        .ready        (per_ready),
        .timer_last   (timer_last),
        .timer_running(timer_running),
        .active       (active),
        .accept       (accept),
        .gap_load     (gap_load),
        .busy         (busy),
        .done         (done)
    );

    pbs_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst    (rst),
        .load   (take),
        .base   (cfg_addr),
        .adv    (accept),
        .incr_en(cfg_q.incr_en),
        .step   (cfg_q.step),
        .addr   (per_addr)
    );

    pbs_gap_timer #(.GAP_UNIT(GAP_UNIT), .CODE_W(3)) u_gap (
        .clk    (clk),
        .rst    (rst),
        .load   (gap_load),
        .code   (cfg_q.gap),
        .last   (timer_last),
        .running(timer_running)
    );

    assign per_rd    = active && cfg_q.dir;
    assign per_wr    = active && !cfg_q.dir;
    assign per_wdata = cfg_q.swap ? lane_rev(mem_wdata, cfg_q.unit_w) : mem_wdata;
    assign mem_rdata = cfg_q.swap ? lane_rev(per_rdata, cfg_q.unit_w) : per_rdata;

    // R2: read and write strobes are exclusive
    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !(per_rd && per_wr));

    // R4: a stalled access holds strobe and address
    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((per_rd || per_wr) && !per_ready) |=>
            ($stable(per_rd) && $stable(per_wr) && $stable(per_addr)));

endmodule

// File: tb/test_periph_burst_seq.sv
module test_periph_burst_seq;

    typedef struct packed {
        logic [31:0] base;
        logic [15:0] len;
        logic [1:0]  uw;
        logic        inc;
        logic [1:0]  isz;
        logic [2:0]  bst;
        logic [2:0]  dly;
        logic        dir;
        logic        swp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{32'h0000_1000, 16'd5, 2'd0, 1'b1, 2'd0, 3'd0, 3'd0, 1'b0, 1'b0},
        '{32'h0000_2000, 16'd6, 2'd1, 1'b1, 2'd1, 3'd2, 3'd1, 1'b1, 1'b1},
        '{32'h0000_3003, 16'd7, 2'd2, 1'b1, 2'd2, 3'd3, 3'd2, 1'b0, 1'b1},
        '{32'h0000_4000, 16'd4, 2'd0, 1'b0, 2'd0, 3'd4, 3'd3, 1'b1, 1'b1},
        '{32'h0000_5000, 16'd3, 2'd0, 1'b1, 2'd3, 3'd1, 3'd7, 1'b0, 1'b1},
        '{32'h0000_6000, 16'd9, 2'd1, 1'b1, 2'd0, 3'd7, 3'd1, 1'b0, 1'b0},
        '{32'h0000_7000, 16'd0, 2'd0, 1'b1, 2'd0, 3'd2, 3'd1, 1'b1, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] cfg_addr = '0;
    logic [15:0] cfg_len = '0;
    logic [1:0]  cfg_unit_w = '0;
    logic        cfg_incr_en = 1'b0;
    logic [1:0]  cfg_step = '0;
    logic [2:0]  cfg_burst = '0;
    logic [2:0]  cfg_gap = '0;
    logic        cfg_dir = 1'b0;
    logic        cfg_swap = 1'b0;
    logic        per_ready = 1'b0;
    logic [31:0] per_rdata = '0;
    logic [31:0] mem_wdata = '0;
    logic        per_rd, per_wr, busy, done;
    logic [31:0] per_addr, per_wdata, mem_rdata;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    periph_burst_seq i_periph_burst_seq (
        .clk(clk), .rst(rst), .start(start), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_unit_w(cfg_unit_w), .cfg_incr_en(cfg_incr_en),
        .cfg_step(cfg_step), .cfg_burst(cfg_burst), .cfg_gap(cfg_gap),
        .cfg_dir(cfg_dir), .cfg_swap(cfg_swap), .per_ready(per_ready),
        .per_rdata(per_rdata), .mem_wdata(mem_wdata), .per_rd(per_rd),
        .per_wr(per_wr), .per_addr(per_addr), .per_wdata(per_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] want_swap(input logic [31:0] d,
                                              input logic [1:0] w, input logic s);
        logic [31:0] r;
        r = d;
        if (s && w == 2'd0) begin
            for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
        end else if (s && w == 2'd1) begin
            r[7:0]  = d[15:8];
            r[15:8] = d[7:0];
        end
        return r;
    endfunction

    task automatic check_idle(input string tag);
        chk(!per_rd && !per_wr, "R1", {tag, " strobes"}, {30'd0, per_rd, per_wr}, 0);
        chk(!busy, "R1", {tag, " busy"}, {31'd0, busy}, 0);
        chk(!done, "R1", {tag, " done"}, {31'd0, done}, 0);
    endtask

    task automatic run_vec(input vec_t v, input bit restart_mid);
        int k = 0;
        int idle = 0;
        int beff;
        int step;
        int guard = 0;
        int exp_gap;
        bit gap_open = 1'b0;
        bit seen_done = 1'b0;
        logic [31:0] exp_addr;
        beff = (v.bst == 3'd0) ? 1 : int'(v.bst);
        step = (v.isz == 2'd0) ? 4 : (v.isz == 2'd1) ? 2 : 1;
        @(negedge clk);
        cfg_addr = v.base; cfg_len = v.len; cfg_unit_w = v.uw;
        cfg_incr_en = v.inc; cfg_step = v.isz; cfg_burst = v.bst;
        cfg_gap = v.dly; cfg_dir = v.dir; cfg_swap = v.swp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R9: scramble configuration once the descriptor is taken
        cfg_addr = ~v.base; cfg_len = 16'd40; cfg_unit_w = ~v.uw;
        cfg_incr_en = ~v.inc; cfg_step = ~v.isz; cfg_burst = ~v.bst;
        cfg_gap = 3'd0; cfg_dir = ~v.dir; cfg_swap = ~v.swp;
        while (!seen_done && guard < 20000) begin
            guard++;
            cyc++;
            start = 1'b0;
            mem_wdata = 32'h1122_3300 + k * 32'h0104_0801;
            per_rdata = ~mem_wdata ^ 32'h00F0_0F00;
            #1;
            if (done) begin
                seen_done = 1'b1;
                chk(k == int'(v.len), "R5", "unit count at done", k, v.len);
                chk(!per_rd && !per_wr, "R7", "no gap or strobe after final burst",
                    {30'd0, per_rd, per_wr}, 0);
            end else if (per_rd || per_wr) begin
                if (gap_open) begin
                    exp_gap = ((k % beff) == 0) ? int'(v.dly) * 256 : 0;
                    chk(idle == exp_gap, "R7", "quiet cycles between units (R6 burst grouping)",
                        idle, exp_gap);
                    gap_open = 1'b0;
                end
                exp_addr = v.base + (v.inc ? k * step : 0);
                chk(per_addr == exp_addr, "R3", "access address", per_addr, exp_addr);
                chk(per_rd == v.dir && per_wr == !v.dir, "R2", "strobe direction",
                    {30'd0, per_rd, per_wr}, {30'd0, v.dir, !v.dir});
                chk(per_wdata == want_swap(mem_wdata, v.uw, v.swp), "R8", "write data lanes",
                    per_wdata, want_swap(mem_wdata, v.uw, v.swp));
                chk(mem_rdata == want_swap(per_rdata, v.uw, v.swp), "R8", "read data lanes",
                    mem_rdata, want_swap(per_rdata, v.uw, v.swp));
                per_ready = ((cyc % 3) != 1);
                if (per_ready) begin
                    k++;
                    gap_open = 1'b1;
                    idle = 0;
                    if (restart_mid && k == 1) start = 1'b1;
                end
            end else begin
                per_ready = 1'b0;
                idle++;
            end
            @(negedge clk);
        end
        per_ready = 1'b0;
        #1;
        chk(seen_done, "R5", "done seen", {31'd0, seen_done}, 1);
        chk(!done, "R5", "done lasts one cycle", {31'd0, done}, 0);
        chk(!busy, "R5", "busy falls with done", {31'd0, busy}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R5 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        check_idle("after reset");

        // table walk: widths, step codes, bursts, gaps, directions, swap
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i == 5);
        end

        // R1: reset in the middle of a gap returns the block to idle
        @(negedge clk);
        cfg_addr = 32'h0000_8000; cfg_len = 16'd6; cfg_incr_en = 1'b1;
        cfg_step = 2'd0; cfg_burst = 3'd1; cfg_gap = 3'd5; cfg_dir = 1'b0;
        cfg_swap = 1'b0; start = 1'b1; per_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        per_ready = 1'b0;
        #1;
        check_idle("after mid-transfer reset");

        // R9: a fresh descriptor after reset runs normally with restart attempt
        run_vec(VECS[1], 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule